// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block keeps a small, fully associative set of recent virtual-to-physical page translations for a device-side address translator. Each line holds a 7-bit address-space identifier, the 20-bit virtual page number (VA[31:12]), the physical frame number and a small permission field. The lookup port takes an identifier and a 32-bit virtual address. A hit returns the frame and the permissions one cycle later. A miss is sent to an external table walker through a request port. When the walker returns the translation, the block installs it and answers the pending lookup.

Software invalidates stale lines through a single 32-bit command word. Bits [1:0] select how addresses are matched. Bit 31 can limit the command to one identifier. The address field is either a 4 MB section or a 16 KB group. Two static settings control the block: how many lines may receive new translations, and whether hits may still be answered while a walk is in flight.

Lookup and walk request are valid/ready streams. A transfer happens on a rising edge where valid and ready are both high. The lookup source must hold valid and its payload stable until ready is seen. The block holds `wk_valid` and its payload until the walker raises `wk_ready`. The response and the refill ports have no back-pressure. The response consumer must take `rsp_valid` in the cycle it is high. A refill is accepted in any cycle once the walk request has been taken and before the refill arrives; `rf_valid` at any other time is ignored.

Top module: `asid_tlb`

## Requirements
- R1: After reset every line is invalid, `rsp_valid` and `wk_valid` are 0 and `lk_ready` is 1, so the first lookup of any address misses.
- R2: An accepted lookup hits when a valid line holds the same identifier and VA[31:12]. VA[11:0] plays no part in the match. One cycle after acceptance, `rsp_valid`=1 and `rsp_hit`=1, with the stored frame and permissions. The same page under another identifier misses.
- R3: An accepted lookup that misses raises `wk_valid` in the next cycle, carrying the identifier and VA[31:12]. `wk_valid` and that payload stay stable until `wk_ready` is seen. After the request is taken, a refill cycle (`rf_valid`=1) installs the translation. In the following cycle it gives `rsp_valid`=1 and `rsp_hit`=0, with the refilled frame and permissions.
- R4: At most one miss is outstanding. From the cycle after a miss is accepted until the refill cycle, `lk_ready` is 0 when `cfg_hum`=0. When `cfg_hum`=1, `lk_ready` is 1 only for a lookup that hits, and that lookup is answered as in R2. `lk_ready` is 0 in the refill cycle itself.
- R5: A command with `fl_valid`=1 invalidates lines according to its mode in bits [1:0]:
  - code 0 matches every address.
  - code 2 matches lines whose VA[31:22] equals command bits [19:10].
  - code 3 matches lines whose VA[31:14] equals command bits [19:2].
  - code 1 has no effect.
  Command bits that the selected mode does not use are ignored.
- R6: When command bit 31 is 1, a command only affects lines whose identifier equals command bits [30:24]. When bit 31 is 0, the identifier is not compared.
- R7: A command in the same cycle as a refill also applies to the translation being installed. If it matches, the line is left invalid, but the refill response is still delivered.
- R8: `cfg_lines` is a 6-bit count of the lines that may receive refills, lowest indices first. A value of 0, or any value of at least ENTRIES, means all ENTRIES lines. Under the default setting of 32 with ENTRIES=32, every line is usable.
- R9: A refill goes to the lowest-indexed invalid line among the usable ones. If none is invalid, it replaces the line at a round-robin pointer. The pointer starts at 0 after reset, is taken as 0 if it lies outside the usable range, and moves to the next usable line, wrapping, after each replacement.
- R10: A lookup accepted in the same cycle as an invalidating command is answered from the contents before the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_lines | input | 6 | Number of lines usable for refill (0 = all) |
| cfg_hum | input | 1 | Allow hits to be answered while a walk is outstanding |
| fl_valid | input | 1 | Invalidation command strobe |
| fl_cmd | input | 32 | Invalidation command word |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted when high with valid |
| lk_asid | input | 7 | Lookup address-space identifier |
| lk_va | input | 32 | Lookup virtual address |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | 1 = answered from a cached line, 0 = answered by refill |
| rsp_pfn | output | PFN_W (20) | Physical frame number |
| rsp_perm | output | PERM_W (3) | Permission bits |
| wk_valid | output | 1 | Walk request valid |
| wk_ready | input | 1 | Walk request taken |
| wk_asid | output | 7 | Identifier to walk |
| wk_vpn | output | 20 | Virtual page number (VA[31:12]) to walk |
| rf_valid | input | 1 | Refill strobe from the walker |
| rf_pfn | input | PFN_W (20) | Refilled physical frame number |
| rf_perm | input | PERM_W (3) | Refilled permission bits |

## Verification
The bench builds the block with ENTRIES=8. Its address pool holds 48 distinct pages across three identifiers, two sections and two groups, so full-buffer replacement happens often, and section and group commands hit partly populated lines. The bench also sets `cfg_lines` to 1, 2, 3, 0 and 12. That brings the clamping rule and round-robin wrap at short lengths within reach, along with a pointer left outside a shrunken range.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;

  localparam int ID_W  = 7;
  localparam int VA_W  = 32;
  localparam int PG_SH = 12;
  localparam int VPN_W = VA_W - PG_SH;

  typedef struct packed {
    logic [ID_W-1:0]  asid;
    logic [VPN_W-1:0] vpn;
  } tag_t;

  typedef enum logic [1:0] {
    KILL_ANY  = 2'd0,
    KILL_NONE = 2'd1,
    KILL_SECT = 2'd2,
    KILL_GRP  = 2'd3
  } kill_mode_e;

  function automatic logic kill_match(input tag_t t, input logic [31:0] cmd);
    logic id_ok;
    logic addr_ok;
    id_ok = !cmd[31] || (t.asid == cmd[30:24]);
    case (kill_mode_e'(cmd[1:0]))
      KILL_ANY:  addr_ok = 1'b1;
      KILL_SECT: addr_ok = (t.vpn[19:10] == cmd[19:10]);
      KILL_GRP:  addr_ok = (t.vpn[19:2] == cmd[19:2]);
      default:   addr_ok = 1'b0;
    endcase
    return id_ok && addr_ok;
  endfunction

endpackage

// File: rtl/asid_tlb_line.sv
module asid_tlb_line
  import asid_tlb_pkg::*;
#(
  parameter int PFN_W  = 20,
  parameter int PERM_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tag_t              lk_tag,
  input  logic              fl_valid,
  input  logic [31:0]       fl_cmd,
  input  logic              wr_en,
  input  tag_t              wr_tag,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic [PERM_W-1:0] wr_perm,
  output logic              o_valid,
  output logic              o_hit,
  output logic [PFN_W-1:0]  o_pfn,
  output logic [PERM_W-1:0] o_perm
);

  logic              vld_q;
  tag_t              tag_q;
  logic [PFN_W-1:0]  pfn_q;
  logic [PERM_W-1:0] perm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      tag_q  <= '0;
      pfn_q  <= '0;
      perm_q <= '0;
    end else begin
      if (wr_en) begin
        vld_q  <= !(fl_valid && kill_match(wr_tag, fl_cmd));
        tag_q  <= wr_tag;
        pfn_q  <= wr_pfn;
        perm_q <= wr_perm;
      end else if (fl_valid && kill_match(tag_q, fl_cmd)) begin
        vld_q <= 1'b0;
      end
    end
  end

  assign o_valid = vld_q;
  assign o_hit   = vld_q && (tag_q == lk_tag);
  assign o_pfn   = pfn_q;
  assign o_perm  = perm_q;

endmodule

// File: rtl/asid_tlb_victim.sv
module asid_tlb_victim #(
  parameter int ENTRIES = 32,
  parameter int IDX_W   = $clog2(ENTRIES),
  parameter int CNT_W   = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [5:0]         cfg_lines,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               alloc,
  output logic [IDX_W-1:0]   victim_idx,
  output logic [CNT_W-1:0]   eff_lines
);

  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] ptr_use;
  logic [IDX_W-1:0] free_idx;
  logic             free_found;

  always_comb begin
    if (cfg_lines == 6'd0 || int'(cfg_lines) >= ENTRIES)
      eff_lines = CNT_W'(ENTRIES);
    else
      eff_lines = CNT_W'(cfg_lines);
  end

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (i < int'(eff_lines) && !valid_vec[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end

  assign ptr_use    = (int'(rr_q) < int'(eff_lines)) ? rr_q : '0;
  assign victim_idx = free_found ? free_idx : ptr_use;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (alloc && !free_found) begin
      if (int'(ptr_use) + 1 >= int'(eff_lines)) rr_q <= '0;
      else                                      rr_q <= ptr_use + 1'b1;
    end
  end

endmodule

// File: rtl/asid_tlb_walkctl.sv
module asid_tlb_walkctl
  import asid_tlb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic miss_go,
  input  tag_t miss_tag,
  input  logic wk_ready,
  input  logic rf_valid,
  output logic wk_valid,
  output tag_t wk_tag,
  output logic pending,
  output logic refill_now
);

  typedef enum logic [1:0] {W_IDLE, W_REQ, W_WAIT} wstate_e;

  wstate_e st_q;
  tag_t    tag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= W_IDLE;
      tag_q <= '0;
    end else begin
      case (st_q)
        W_IDLE: if (miss_go) begin
          st_q  <= W_REQ;
          tag_q <= miss_tag;
        end
        W_REQ:  if (wk_ready) st_q <= W_WAIT;
        W_WAIT: if (rf_valid) st_q <= W_IDLE;
        default: st_q <= W_IDLE;
      endcase
    end
  end

  assign wk_valid   = (st_q == W_REQ);
  assign wk_tag     = tag_q;
  assign pending    = (st_q != W_IDLE);
  assign refill_now = (st_q == W_WAIT) && rf_valid;

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import asid_tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int PFN_W   = 20,
  parameter int PERM_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [5:0]        cfg_lines,
  input  logic              cfg_hum,
  input  logic              fl_valid,
  input  logic [31:0]       fl_cmd,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [6:0]        lk_asid,
  input  logic [31:0]       lk_va,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PFN_W-1:0]  rsp_pfn,
  output logic [PERM_W-1:0] rsp_perm,
  output logic              wk_valid,
  input  logic              wk_ready,
  output logic [6:0]        wk_asid,
  output logic [19:0]       wk_vpn,
  input  logic              rf_valid,
  input  logic [PFN_W-1:0]  rf_pfn,
  input  logic [PERM_W-1:0] rf_perm
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int CNT_W = IDX_W + 1;

  tag_t               lk_tag;
  tag_t               wk_tag;
  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES-1:0] wr_vec;
  logic [PFN_W-1:0]   line_pfn  [ENTRIES];
  logic [PERM_W-1:0]  line_perm [ENTRIES];
  logic [PFN_W-1:0]   hit_pfn;
  logic [PERM_W-1:0]  hit_perm;
  logic               any_hit;
  logic               accept;
  logic               miss_go;
  logic               pending;
  logic               refill_now;
  logic [IDX_W-1:0]   victim_idx;
  logic [CNT_W-1:0]   eff_lines;

  assign lk_tag = '{asid: lk_asid, vpn: lk_va[VA_W-1:PG_SH]};

  for (genvar i = 0; i < ENTRIES; i++) begin : g_line
    assign wr_vec[i] = refill_now && (victim_idx == IDX_W'(i));
    asid_tlb_line #(.PFN_W(PFN_W), .PERM_W(PERM_W)) u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_tag   (lk_tag),
      .fl_valid (fl_valid),
      .fl_cmd   (fl_cmd),
      .wr_en    (wr_vec[i]),
      .wr_tag   (wk_tag),
      .wr_pfn   (rf_pfn),
      .wr_perm  (rf_perm),
      .o_valid  (valid_vec[i]),
      .o_hit    (hit_vec[i]),
      .o_pfn    (line_pfn[i]),
      .o_perm   (line_perm[i])
    );
  end

  always_comb begin
    hit_pfn  = '0;
    hit_perm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) begin
        hit_pfn  = hit_pfn | line_pfn[i];
        hit_perm = hit_perm | line_perm[i];
      end
    end
  end

  assign any_hit  = |hit_vec;
  assign lk_ready = !pending || (cfg_hum && any_hit && !refill_now);
  assign accept   = lk_valid && lk_ready;
  assign miss_go  = accept && !any_hit;

  asid_tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_lines  (cfg_lines),
    .valid_vec  (valid_vec),
    .alloc      (refill_now),
    .victim_idx (victim_idx),
    .eff_lines  (eff_lines)
  );

  asid_tlb_walkctl u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_go    (miss_go),
    .miss_tag   (lk_tag),
    .wk_ready   (wk_ready),
    .rf_valid   (rf_valid),
    .wk_valid   (wk_valid),
    .wk_tag     (wk_tag),
    .pending    (pending),
    .refill_now (refill_now)
  );

  assign wk_asid = wk_tag.asid;
  assign wk_vpn  = wk_tag.vpn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_pfn   <= '0;
      rsp_perm  <= '0;
    end else begin
      rsp_valid <= (accept && any_hit) || refill_now;
      rsp_hit   <= accept && any_hit;
      rsp_pfn   <= refill_now ? rf_pfn  : hit_pfn;
      rsp_perm  <= refill_now ? rf_perm : hit_perm;
    end
  end

endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
  parameter int ENTRIES = 32,
  parameter int IDX_W   = $clog2(ENTRIES),
  parameter int CNT_W   = IDX_W + 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_hum,
  input logic               lk_ready,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               wk_valid,
  input logic               wk_ready,
  input logic [6:0]         wk_asid,
  input logic [19:0]        wk_vpn,
  input logic               rf_valid,
  input logic               refill_now,
  input logic [ENTRIES-1:0] hit_vec,
  input logic [IDX_W-1:0]   victim_idx,
  input logic [CNT_W-1:0]   eff_lines
);

  p_walk_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wk_valid && !wk_ready |=> wk_valid && $stable(wk_asid) && $stable(wk_vpn));

  p_miss_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> $past(rf_valid));

  p_single_tag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  p_stall_nohum_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wk_valid && !cfg_hum |-> !lk_ready);

  p_refill_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    refill_now |-> !lk_ready);

  p_alloc_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    refill_now |-> (int'(victim_idx) < int'(eff_lines)));

endmodule

bind asid_tlb asid_tlb_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_hum    (cfg_hum),
  .lk_ready   (lk_ready),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .wk_valid   (wk_valid),
  .wk_ready   (wk_ready),
  .wk_asid    (wk_asid),
  .wk_vpn     (wk_vpn),
  .rf_valid   (rf_valid),
  .refill_now (refill_now),
  .hit_vec    (hit_vec),
  .victim_idx (victim_idx),
  .eff_lines  (eff_lines)
);

// File: tb/asid_tlb_test.sv
`timescale 1ns/1ps
module asid_tlb_test;

  localparam int E = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  cfg_lines = 6'd0;
  logic        cfg_hum = 1'b0;
  logic        fl_valid = 1'b0;
  logic [31:0] fl_cmd = '0;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [6:0]  lk_asid = '0;
  logic [31:0] lk_va = '0;
  logic        rsp_valid, rsp_hit;
  logic [19:0] rsp_pfn;
  logic [2:0]  rsp_perm;
  logic        wk_valid;
  logic        wk_ready = 1'b0;
  logic [6:0]  wk_asid;
  logic [19:0] wk_vpn;
  logic        rf_valid = 1'b0;
  logic [19:0] rf_pfn = '0;
  logic [2:0]  rf_perm = '0;

  asid_tlb #(.ENTRIES(E), .PFN_W(20), .PERM_W(3)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_lines(cfg_lines), .cfg_hum(cfg_hum),
    .fl_valid(fl_valid), .fl_cmd(fl_cmd),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_asid(lk_asid), .lk_va(lk_va),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pfn(rsp_pfn), .rsp_perm(rsp_perm),
    .wk_valid(wk_valid), .wk_ready(wk_ready), .wk_asid(wk_asid), .wk_vpn(wk_vpn),
    .rf_valid(rf_valid), .rf_pfn(rf_pfn), .rf_perm(rf_perm)
  );

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench model of the buffer contents
  bit         m_v [E];
  logic [6:0] m_a [E];
  logic [19:0] m_n [E];
  int         m_rr = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [19:0] pfn_of(input logic [6:0] a, input logic [19:0] n);
    return n ^ {a, 13'h0a5b} ^ 20'h3c3c3;
  endfunction

  function automatic logic [2:0] perm_of(input logic [6:0] a, input logic [19:0] n);
    return n[2:0] ^ a[2:0] ^ n[12:10];
  endfunction

  function automatic bit kill(input logic [6:0] a, input logic [19:0] n, input logic [31:0] c);
    if (c[1:0] == 2'd1) return 1'b0;
    if (c[31] && a != c[30:24]) return 1'b0;
    if (c[1:0] == 2'd0) return 1'b1;
    if (c[1:0] == 2'd2) return n[19:10] == c[19:10];
    return n[19:2] == c[19:2];
  endfunction

  function automatic int m_eff();
    if (cfg_lines == 0 || int'(cfg_lines) >= E) return E;
    return int'(cfg_lines);
  endfunction

  function automatic int m_find(input logic [6:0] a, input logic [19:0] n);
    for (int i = 0; i < E; i++)
      if (m_v[i] && m_a[i] == a && m_n[i] == n) return i;
    return -1;
  endfunction

  function automatic int m_take();
    int p;
    for (int i = 0; i < m_eff(); i++)
      if (!m_v[i]) return i;
    p = (m_rr < m_eff()) ? m_rr : 0;
    m_rr = (p + 1 >= m_eff()) ? 0 : p + 1;
    return p;
  endfunction

  function automatic void m_flush(input logic [31:0] c, input int skip);
    for (int i = 0; i < E; i++)
      if (i != skip && m_v[i] && kill(m_a[i], m_n[i], c)) m_v[i] = 1'b0;
  endfunction

  task automatic do_flush(input logic [31:0] c);
    @(negedge clk);
    fl_valid = 1'b1; fl_cmd = c;
    @(negedge clk);
    fl_valid = 1'b0;
    m_flush(c, -1);
  endtask

  // complete an outstanding walk; optional command in the refill cycle
  task automatic finish_walk(input logic [6:0] a, input logic [19:0] n,
                             input bit fl_on, input logic [31:0] c, input string req);
    int v;
    repeat ($urandom % 3) @(negedge clk);
    chk(wk_valid === 1'b1 && wk_asid === a && wk_vpn === n, req, "walk request",
        {wk_valid, wk_asid, wk_vpn}, {1'b1, a, n});
    wk_ready = 1'b1;
    @(negedge clk);
    wk_ready = 1'b0;
    chk(wk_valid === 1'b0, req, "walk taken", wk_valid, 0);
    repeat ($urandom % 3) @(negedge clk);
    rf_valid = 1'b1; rf_pfn = pfn_of(a, n); rf_perm = perm_of(a, n);
    if (fl_on) begin fl_valid = 1'b1; fl_cmd = c; end
    @(negedge clk);
    rf_valid = 1'b0; fl_valid = 1'b0;
    chk(rsp_valid === 1'b1 && rsp_hit === 1'b0 && rsp_pfn === pfn_of(a, n) && rsp_perm === perm_of(a, n),
        req, "refill response", {rsp_valid, rsp_hit, rsp_pfn, rsp_perm},
        {2'b10, pfn_of(a, n), perm_of(a, n)});
    v = m_take();
    if (fl_on) m_flush(c, v);
    m_v[v] = !(fl_on && kill(a, n, c));
    m_a[v] = a; m_n[v] = n;
  endtask

  task automatic lookup(input logic [6:0] a, input logic [31:0] va,
                        input bit fl_on, input logic [31:0] c, input string req);
    int idx;
    logic [19:0] n;
    n = va[31:12];
    idx = m_find(a, n);
    @(negedge clk);
    lk_valid = 1'b1; lk_asid = a; lk_va = va;
    #1;
    chk(lk_ready === 1'b1, req, "ready when idle", lk_ready, 1);
    @(negedge clk);
    lk_valid = 1'b0;
    if (idx >= 0) begin
      chk(rsp_valid === 1'b1 && rsp_hit === 1'b1 && rsp_pfn === pfn_of(a, n) && rsp_perm === perm_of(a, n),
          req, "hit response", {rsp_valid, rsp_hit, rsp_pfn, rsp_perm},
          {2'b11, pfn_of(a, n), perm_of(a, n)});
    end else begin
      chk(rsp_valid === 1'b0 && wk_valid === 1'b1, req, "miss expected",
          {rsp_valid, wk_valid}, 2'b01);
      finish_walk(a, n, fl_on, c, req);
    end
  endtask

  function automatic logic [31:0] pool_va(input int s, input int g, input int p);
    logic [9:0] sec;
    logic [7:0] grp;
    sec = (s == 0) ? 10'h155 : 10'h2aa;
    grp = (g == 0) ? 8'h0f : 8'hf0;
    return {sec, grp, 2'(p), 12'($urandom)};
  endfunction

  function automatic logic [6:0] pool_id(input int k);
    return (k == 0) ? 7'd1 : (k == 1) ? 7'd2 : 7'd77;
  endfunction

  initial begin
    #1600000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] va_a, va_b, va_c, va_d;
    void'($urandom(32'd4242));
    for (int i = 0; i < E; i++) m_v[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(rsp_valid === 1'b0 && wk_valid === 1'b0 && lk_ready === 1'b1, "R1", "reset outputs",
        {rsp_valid, wk_valid, lk_ready}, 3'b001);
    lookup(7'd1, 32'h1234_5678, 0, 0, "R1");

    // R2 offset ignored, identifier matters
    lookup(7'd1, 32'h1234_5abc, 0, 0, "R2");
    lookup(7'd2, 32'h1234_5678, 0, 0, "R2");
    lookup(7'd2, 32'h1234_5000, 0, 0, "R2");

    // R5 section mode
    do_flush(32'h0);
    va_a = 32'h5540_3000; va_b = 32'haa80_3000;
    lookup(7'd1, va_a, 0, 0, "R5");
    lookup(7'd1, va_b, 0, 0, "R5");
    do_flush(((va_a & 32'hffc0_0000) >> 12) | 32'h2);
    lookup(7'd1, va_b, 0, 0, "R5");
    lookup(7'd1, va_a, 0, 0, "R5");
    // R5 group mode, other bits of the command ignored
    va_c = 32'h5540_4000; va_d = 32'h5540_8000;
    lookup(7'd1, va_c, 0, 0, "R5");
    lookup(7'd1, va_d, 0, 0, "R5");
    do_flush(((va_c & 32'hffff_c000) >> 12) | 32'h0060_0003);
    lookup(7'd1, va_d, 0, 0, "R5");
    lookup(7'd1, va_c, 0, 0, "R5");
    // R5 code 1 has no effect
    do_flush(32'h0000_0001);
    lookup(7'd1, va_c, 0, 0, "R5");

    // R6 identifier qualified
    lookup(7'd2, va_c, 0, 0, "R6");
    do_flush(32'h8000_0000 | (32'd2 << 24));
    lookup(7'd1, va_c, 0, 0, "R6");
    lookup(7'd2, va_c, 0, 0, "R6");

    // R7 command during refill
    do_flush(32'h0);
    lookup(7'd5, 32'h0000_1000, 1, 32'h0, "R7");
    lookup(7'd5, 32'h0000_1000, 1, 32'h8000_0000 | (32'd6 << 24), "R7");
    lookup(7'd5, 32'h0000_1000, 0, 0, "R7");

    // R8 / R9 short active lengths
    do_flush(32'h0);
    cfg_lines = 6'd1;
    lookup(7'd3, 32'h0001_0000, 0, 0, "R8");
    lookup(7'd3, 32'h0002_0000, 0, 0, "R8");
    lookup(7'd3, 32'h0001_0000, 0, 0, "R8");
    cfg_lines = 6'd2;
    lookup(7'd3, 32'h0003_0000, 0, 0, "R9");
    lookup(7'd3, 32'h0004_0000, 0, 0, "R9");
    lookup(7'd3, 32'h0001_0000, 0, 0, "R9");
    lookup(7'd3, 32'h0003_0000, 0, 0, "R9");
    cfg_lines = 6'd12;
    lookup(7'd3, 32'h0005_0000, 0, 0, "R8");
    lookup(7'd3, 32'h0004_0000, 0, 0, "R8");

    // R4 single miss, hit under miss
    do_flush(32'h0);
    cfg_lines = 6'd0;
    lookup(7'd4, 32'h7000_0000, 0, 0, "R4");
    @(negedge clk);
    lk_valid = 1'b1; lk_asid = 7'd4; lk_va = 32'h7100_0000;
    @(negedge clk);
    lk_valid = 1'b1; lk_va = 32'h7000_0000; cfg_hum = 1'b0;
    #1;
    chk(lk_ready === 1'b0, "R4", "stall without hit-under-miss", lk_ready, 0);
    cfg_hum = 1'b1;
    #1;
    chk(lk_ready === 1'b1, "R4", "hit accepted under miss", lk_ready, 1);
    @(negedge clk);
    chk(rsp_valid === 1'b1 && rsp_hit === 1'b1 && rsp_pfn === pfn_of(7'd4, 20'h70000), "R4",
        "hit under miss response", {rsp_valid, rsp_hit, rsp_pfn}, {2'b11, pfn_of(7'd4, 20'h70000)});
    lk_va = 32'h7200_0000;
    #1;
    chk(lk_ready === 1'b0, "R4", "second miss stalls", lk_ready, 0);
    lk_valid = 1'b0;
    wk_ready = 1'b1;
    @(negedge clk);
    wk_ready = 1'b0;
    lk_valid = 1'b1; lk_va = 32'h7000_0000;
    rf_valid = 1'b1; rf_pfn = pfn_of(7'd4, 20'h71000); rf_perm = perm_of(7'd4, 20'h71000);
    #1;
    chk(lk_ready === 1'b0, "R4", "refill cycle stalls", lk_ready, 0);
    @(negedge clk);
    rf_valid = 1'b0; lk_valid = 1'b0;
    chk(rsp_valid === 1'b1 && rsp_hit === 1'b0 && rsp_pfn === pfn_of(7'd4, 20'h71000), "R4",
        "refill after hit under miss", {rsp_valid, rsp_hit, rsp_pfn}, {2'b10, pfn_of(7'd4, 20'h71000)});
    begin
      int v;
      v = m_take();
      m_v[v] = 1'b1; m_a[v] = 7'd4; m_n[v] = 20'h71000;
    end
    lookup(7'd4, 32'h7100_0abc, 0, 0, "R4");

    // R10 lookup with command in the same cycle
    @(negedge clk);
    lk_valid = 1'b1; lk_asid = 7'd4; lk_va = 32'h7000_0000;
    fl_valid = 1'b1; fl_cmd = 32'h0;
    @(negedge clk);
    lk_valid = 1'b0; fl_valid = 1'b0;
    chk(rsp_valid === 1'b1 && rsp_hit === 1'b1, "R10", "pre-command answer",
        {rsp_valid, rsp_hit}, 2'b11);
    m_flush(32'h0, -1);
    lookup(7'd4, 32'h7000_0000, 0, 0, "R10");

    // random phase
    cfg_hum = 1'b0;
    for (int k = 0; k < 500; k++) begin
      int r;
      logic [31:0] va, c;
      logic [6:0] a;
      r = int'($urandom % 100);
      a = pool_id(int'($urandom % 3));
      va = pool_va(int'($urandom % 2), int'($urandom % 2), int'($urandom % 4));
      c = {1'($urandom), pool_id(int'($urandom % 3)), 24'h0};
      case ($urandom % 4)
        0: c = c | (32'($urandom) & 32'h00ff_fffc);
        1: c = c | (32'($urandom) & 32'h00ff_fffc) | 32'h1;
        2: c = c | ((va & 32'hffc0_0000) >> 12) | 32'h2;
        default: c = c | ((va & 32'hffff_c000) >> 12) | 32'h3;
      endcase
      if (r < 4) begin
        case ($urandom % 4)
          0: cfg_lines = 6'd0;
          1: cfg_lines = 6'd3;
          2: cfg_lines = 6'd8;
          default: cfg_lines = 6'd5;
        endcase
      end else if (r < 16) begin
        do_flush(c);
      end else begin
        lookup(a, va, (r > 90), c, (r > 90) ? "R7" : "R9");
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule